// File: doc/BRIEF.md
# Debug Port Host Transfer Master

This block is the host side of a synchronous serial debug link to a processor halted in its background debug state. A start strobe hands it a 16-bit payload. It then runs one full-duplex 17-bit frame. It generates the debug clock, shifts the outgoing word onto the data line toward the target, and collects the target's reply from the return line. Both directions send the most significant bit first. The extra top bit of each outgoing word is a control flag that the host always sends as zero.

When the frame ends, the block sorts the 17-bit reply into one of five message classes. It then pulses a done strobe, and the reply and its class stay on the outputs. The target can answer "not ready". When that happens, the block can resend no-operation frames on its own until a real answer arrives or a retry limit set by software is reached. A divider input sets the length of each debug-clock half-period in system clocks. The block handles exactly one word per start, and any sequencing of multi-word commands belongs to the logic above it.

Top module: `dbg_xfer_master`

## Requirements
- R1: The outgoing frame is 17 bits sent MSB first on `dsi_o`, and bit 16 is always 0. The target therefore receives `{1'b0, payload_i}` as captured when the start strobe was accepted. `dsi_o` changes only while `dsclk_o` is low.
- R2: `dsclk_o` is high whenever the block is idle. Each frame has 17 low/high half-period pairs. Each half-period lasts H = max(`div_i`, 2) system clocks, with `div_i` captured at the start strobe. `done_o` rises exactly 34·H·F cycles after the edge that accepted the start, where F is the number of frames issued.
- R3: The reply is sampled from `dso_i` at the last system clock of each low half-period, MSB first. All 17 bits are presented on `reply_o` at `done_o`.
- R4: `class_o` encodes the final reply as follows. 0 means data: bit 16 clear and a value other than FFFF. 1 means complete: bit 16 clear and value FFFF. 2 means not ready: bit 16 set and value 0000. 3 means bus error: bit 16 set and value 0001. 4 means illegal command: bit 16 set and value FFFF, or bit 16 set with any other value.
- R5: While the reply is not ready and fewer than `retry_max_i` retries have been made, the block sends another frame carrying the NOP payload 0000. It does so back to back, with no done strobe in between. A `retry_max_i` of 0 turns retrying off.
- R6: `timeout_o` is set at `done_o` exactly when the final class is not ready and `retry_max_i` is nonzero. Otherwise it is cleared.
- R7: A start strobe while busy is ignored. It starts no frame, and the payload and divider inputs have no effect on the frame in flight.
- R8: After reset, `dsclk_o` is 1, `busy_o` and `done_o` are 0, and `reply_o`, `class_o` and `timeout_o` are 0.
- R9: `done_o` is a single-cycle pulse in the cycle after `busy_o` falls. `reply_o` changes only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| payload_i | input | 16 | Word to send, bits 15..0 of the frame |
| div_i | input | 8 | Half-period length in system clocks, clamped to at least 2 |
| retry_max_i | input | 4 | Maximum number of not-ready retries, 0 disables retrying |
| dsclk_o | output | 1 | Debug clock toward target, idles high |
| dsi_o | output | 1 | Serial data toward target |
| dso_i | input | 1 | Serial data from target |
| busy_o | output | 1 | Frame sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| reply_o | output | 17 | Final reply word |
| class_o | output | 3 | Message class of the final reply |
| timeout_o | output | 1 | Retry limit reached while target not ready |

## Verification
The bench builds the block with its default widths: a 16-bit payload, an 8-bit divider, a 4-bit retry count and a minimum half-period of 2. It uses divider values from 0 to 5. The values 0 and 1 land on the clamp, and the larger ones stretch the half-period, so the frame-length arithmetic is tested at several rates. Retry limits of 2 and 3 exercise both ways a retry sequence can end: a data reply arriving after two not-ready answers, and the limit being reached while the target is still not ready.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;
   typedef enum logic [2:0] {
      CLS_DATA    = 3'd0,
      CLS_OK      = 3'd1,
      CLS_WAIT    = 3'd2,
      CLS_BUSERR  = 3'd3,
      CLS_ILLEGAL = 3'd4
   } dbg_cls_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } dbg_st_e;
endpackage

// File: rtl/dbg_half_timer.sv
module dbg_half_timer #(
   parameter int DIV_W    = 8,
   parameter int MIN_HALF = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             active_i,
   output logic             tick_o
);
   localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);

   logic [DIV_W-1:0] half_q;
   logic [DIV_W-1:0] half_d;
   logic [DIV_W-1:0] cnt_q;

   generate
      if (MIN_HALF <= 1) begin : g_noclamp
         assign half_d = (div_i == '0) ? DIV_W'(1) : div_i;
      end else begin : g_clamp
         assign half_d = (div_i < MIN_V) ? MIN_V : div_i;
      end
   endgenerate

   assign tick_o = active_i && (cnt_q == half_q - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= MIN_V;
         cnt_q  <= '0;
      end else begin
         if (load_i) half_q <= half_d;
         if (load_i || !active_i || tick_o) cnt_q <= '0;
         else                               cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/dbg_frame_shifter.sv
module dbg_frame_shifter #(
   parameter int DATA_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic            shift_i,
   input  logic            sample_i,
   input  logic            dso_i,
   output logic            dsi_o,
   output logic [DATA_W:0] rx_o
);
   localparam int FRAME_W = DATA_W + 1;

   logic [FRAME_W-1:0] tx_q;
   logic [FRAME_W-1:0] rx_q;

   assign dsi_o = tx_q[FRAME_W-1];
   assign rx_o  = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else begin
         if (load_i)       tx_q <= {1'b0, word_i};
         else if (shift_i) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
         if (sample_i)     rx_q <= {rx_q[FRAME_W-2:0], dso_i};
      end
   end
endmodule

// File: rtl/dbg_reply_classify.sv
module dbg_reply_classify
   import dbg_xfer_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W:0] word_i,
   output dbg_cls_e        cls_o
);
   localparam logic [DATA_W-1:0] ALL1 = '1;
   localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

   logic [DATA_W-1:0] val;
   assign val = word_i[DATA_W-1:0];

   always_comb begin
      if (!word_i[DATA_W]) begin
         cls_o = (val == ALL1) ? CLS_OK : CLS_DATA;
      end else if (val == '0) begin
         cls_o = CLS_WAIT;
      end else if (val == ONE) begin
         cls_o = CLS_BUSERR;
      end else begin
         cls_o = CLS_ILLEGAL;
      end
   end
endmodule

// File: rtl/dbg_xfer_master.sv
module dbg_xfer_master
   import dbg_xfer_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DIV_W    = 8,
   parameter int RETRY_W  = 4,
   parameter int MIN_HALF = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [DATA_W-1:0]  payload_i,
   input  logic [DIV_W-1:0]   div_i,
   input  logic [RETRY_W-1:0] retry_max_i,
   output logic               dsclk_o,
   output logic               dsi_o,
   input  logic               dso_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [DATA_W:0]    reply_o,
   output logic [2:0]         class_o,
   output logic               timeout_o
);
   localparam int FRAME_W = DATA_W + 1;
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
      if (RETRY_W < 1) begin : g_bad_retry
         $error("RETRY_W must be at least 1");
      end
      if (MIN_HALF < 1 || MIN_HALF >= (1 << DIV_W)) begin : g_bad_min
         $error("MIN_HALF out of range for DIV_W");
      end
   endgenerate

   dbg_st_e            st_q;
   logic [BIT_W-1:0]   bit_q;
   logic [RETRY_W-1:0] retry_q;
   logic [RETRY_W-1:0] rmax_q;
   logic               tick;
   logic               accept;
   logic               frame_end;
   logic               retry_go;
   logic               load;
   logic [DATA_W-1:0]  load_word;
   logic [DATA_W:0]    rx_word;
   dbg_cls_e           cls;

   assign accept    = (st_q == ST_IDLE) && start_i;
   assign frame_end = (st_q == ST_HIGH) && tick && (bit_q == LAST_BIT);
   assign retry_go  = frame_end && (cls == CLS_WAIT) && (retry_q < rmax_q);
   assign load      = accept || retry_go;
   assign load_word = accept ? payload_i : '0;
   assign dsclk_o   = (st_q != ST_LOW);

   dbg_half_timer #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept),
      .div_i    (div_i),
      .active_i (busy_o),
      .tick_o   (tick)
   );

   dbg_frame_shifter #(.DATA_W(DATA_W)) shifter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .word_i   (load_word),
      .shift_i  ((st_q == ST_HIGH) && tick && (bit_q != LAST_BIT)),
      .sample_i ((st_q == ST_LOW) && tick),
      .dso_i    (dso_i),
      .dsi_o    (dsi_o),
      .rx_o     (rx_word)
   );

   dbg_reply_classify #(.DATA_W(DATA_W)) classify_i (
      .word_i (rx_word),
      .cls_o  (cls)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         bit_q     <= '0;
         retry_q   <= '0;
         rmax_q    <= '0;
         busy_o    <= 1'b0;
         done_o    <= 1'b0;
         reply_o   <= '0;
         class_o   <= 3'd0;
         timeout_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q    <= ST_LOW;
                  busy_o  <= 1'b1;
                  bit_q   <= '0;
                  retry_q <= '0;
                  rmax_q  <= retry_max_i;
               end
            end
            ST_LOW: begin
               if (tick) st_q <= ST_HIGH;
            end
            ST_HIGH: begin
               if (tick) begin
                  if (bit_q != LAST_BIT) begin
                     bit_q <= bit_q + BIT_W'(1);
                     st_q  <= ST_LOW;
                  end else if (retry_go) begin
                     retry_q <= retry_q + RETRY_W'(1);
                     bit_q   <= '0;
                     st_q    <= ST_LOW;
                  end else begin
                     st_q      <= ST_IDLE;
                     busy_o    <= 1'b0;
                     done_o    <= 1'b1;
                     reply_o   <= rx_word;
                     class_o   <= cls;
                     timeout_o <= (cls == CLS_WAIT) && (rmax_q != '0);
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dbg_xfer_master_chk.sv
module dbg_xfer_master_chk #(
   parameter int DATA_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dsclk_o,
   input logic            dsi_o,
   input logic            busy_o,
   input logic            done_o,
   input logic [DATA_W:0] reply_o,
   input logic [2:0]      class_o,
   input logic            timeout_o
);
   // R2: clock rests high outside a transfer
   a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> dsclk_o);

   // R2: a low half-period spans at least two system clocks
   a_r2_min_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dsclk_o) |=> !dsclk_o);

   // R1: outgoing data holds still while the debug clock is high
   a_r1_dsi_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && dsclk_o && $past(dsclk_o)) |-> $stable(dsi_o));

   // R9: completion strobe is one cycle and follows the busy interval
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R9: reply output only moves with the strobe
   a_r9_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(reply_o));

   // R6: timeout only reported with a not-ready class
   a_r6_timeout_class: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && timeout_o) |-> (class_o == 3'd2));
endmodule

bind dbg_xfer_master dbg_xfer_master_chk #(.DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .dsclk_o   (dsclk_o),
   .dsi_o     (dsi_o),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .reply_o   (reply_o),
   .class_o   (class_o),
   .timeout_o (timeout_o)
);

// File: tb/dbg_xfer_master_tb.sv
module dbg_xfer_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] payload = '0;
   logic [7:0]  div = 8'd2;
   logic [3:0]  rmax = '0;
   logic        dsclk, dsi, dso, busy, done, timeout;
   logic [16:0] reply;
   logic [2:0]  cls;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   dbg_xfer_master dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .payload_i(payload),
      .div_i(div), .retry_max_i(rmax), .dsclk_o(dsclk), .dsi_o(dsi),
      .dso_i(dso), .busy_o(busy), .done_o(done), .reply_o(reply),
      .class_o(cls), .timeout_o(timeout)
   );

   // target model
   logic [16:0] rep [8];
   logic [16:0] cmd_log [8];
   logic [16:0] t_tx, t_rx;
   int          t_cnt, rep_idx, cmd_n;
   logic        tgt_clear = 1'b0;

   assign dso = t_tx[16 - t_cnt];

   always @(posedge dsclk or posedge tgt_clear) begin
      if (tgt_clear) begin
         t_cnt = 0; rep_idx = 0; cmd_n = 0; t_tx = rep[0]; t_rx = '0;
      end else if (rst_n) begin
         t_rx = {t_rx[15:0], dsi};
         if (t_cnt == 16) begin
            if (cmd_n < 8) cmd_log[cmd_n] = t_rx;
            cmd_n = cmd_n + 1;
            t_cnt = 0;
            rep_idx = rep_idx + 1;
            t_tx = rep[rep_idx % 8];
         end else begin
            t_cnt = t_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int half_of(input logic [7:0] d);
      return (d < 8'd2) ? 2 : int'(d);
   endfunction

   task automatic arm_target();
      tgt_clear = 1'b1;
      #1;
      tgt_clear = 1'b0;
   endtask

   task automatic run_xfer(input logic [15:0] p, input logic [7:0] d, input logic [3:0] rm, output int cyc);
      @(negedge clk);
      arm_target();
      payload = p; div = d; rmax = rm; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   localparam int NV = 8;
   localparam logic [15:0] V_PAY [NV] = '{16'h1234, 16'h2180, 16'h8000, 16'hFFFF,
                                          16'h0000, 16'h5A5A, 16'h0F0F, 16'hC3A5};
   localparam logic [16:0] V_REP [NV] = '{17'h0ABCD, 17'h0FFFF, 17'h10001, 17'h1FFFF,
                                          17'h10000, 17'h11234, 17'h00000, 17'h08001};
   localparam logic [2:0]  V_CLS [NV] = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd2, 3'd4, 3'd0, 3'd0};
   localparam logic [7:0]  V_DIV [NV] = '{8'd2, 8'd3, 8'd4, 8'd2, 8'd5, 8'd2, 8'd0, 8'd1};

   initial begin
      for (int i = 0; i < 8; i++) rep[i] = '0;
      #1;
      arm_target();
      #200000000;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int cyc;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(dsclk == 1'b1, "R8 dsclk", 32'(dsclk), 1);
      chk(busy == 1'b0 && done == 1'b0, "R8 busy/done", {busy, done}, 0);
      chk(reply == '0 && cls == 3'd0 && timeout == 1'b0, "R8 outputs", {reply, cls, timeout}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(dsclk == 1'b1, "R2 idle high after reset", 32'(dsclk), 1);

      for (int v = 0; v < NV; v++) begin
         rep[0] = V_REP[v];
         run_xfer(V_PAY[v], V_DIV[v], 4'd0, cyc);
         chk(cyc == 34 * half_of(V_DIV[v]), "R2 frame length", cyc, 34 * half_of(V_DIV[v]));
         chk(cmd_n == 1 && cmd_log[0] == {1'b0, V_PAY[v]}, "R1 word at target", 32'(cmd_log[0]), {15'd0, 1'b0, V_PAY[v]});
         chk(reply == V_REP[v], "R3 reply", 32'(reply), 32'(V_REP[v]));
         chk(cls == V_CLS[v], "R4 class", 32'(cls), 32'(V_CLS[v]));
         chk(timeout == 1'b0, "R6 no timeout when retry off", 32'(timeout), 0);
         @(negedge clk);
         chk(done == 1'b0 && busy == 1'b0 && dsclk == 1'b1, "R9 done single pulse", {done, busy, dsclk}, 1);
      end

      // R5: two not-ready answers, then data
      rep[0] = 17'h10000; rep[1] = 17'h10000; rep[2] = 17'h0BEEF;
      run_xfer(16'h1D40, 8'd3, 4'd3, cyc);
      chk(cyc == 3 * 34 * 3, "R5 retry length", cyc, 306);
      chk(cmd_n == 3, "R5 frame count", cmd_n, 3);
      chk(cmd_log[0] == 17'h01D40 && cmd_log[1] == '0 && cmd_log[2] == '0, "R5 NOP retries", 32'(cmd_log[1]), 0);
      chk(reply == 17'h0BEEF && cls == 3'd0, "R5 final data", 32'(reply), 32'h0BEEF);
      chk(timeout == 1'b0, "R6 no timeout on success", 32'(timeout), 0);

      // R6: limit reached while still not ready
      rep[0] = 17'h10000; rep[1] = 17'h10000; rep[2] = 17'h10000; rep[3] = 17'h10000;
      run_xfer(16'h2187, 8'd2, 4'd2, cyc);
      chk(cyc == 3 * 34 * 2, "R6 timeout length", cyc, 204);
      chk(cmd_n == 3, "R6 frame count", cmd_n, 3);
      chk(timeout == 1'b1 && cls == 3'd2, "R6 timeout flag", {timeout, cls}, 32'h0A);

      // R7: start while busy is ignored
      rep[0] = 17'h04321;
      @(negedge clk);
      arm_target();
      payload = 16'h6A5C; div = 8'd2; rmax = 4'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      payload = 16'hAAAA; div = 8'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 21;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc == 68, "R7 length unchanged", cyc, 68);
      chk(cmd_log[0] == 17'h06A5C, "R7 payload unchanged", 32'(cmd_log[0]), 32'h06A5C);
      repeat (60) @(negedge clk);
      chk(busy == 1'b0 && cmd_n == 1, "R7 no extra frame", cmd_n, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule